// File: doc/BRIEF.md
# Dual-Standard Lock Search Controller

This block decides which of two sound-carrier standards a QPSK carrier-recovery loop is tuned to. Standard A is the 6.552 MHz carrier and standard B is the 5.85 MHz carrier. A single output bit selects between them. In automatic operation the controller gives each standard a window of a fixed number of timer ticks. If the loop reports lock within that window, the controller stays on that standard. If it does not, the controller moves to the other standard and opens a new window.

After lock has been reached, a short dropout in the lock flag does not restart the search. The search resumes only after lock has been missing for a programmable number of ticks. A register bit can override the search and pin either standard directly. Two further register bits, the crystal choice and the synthesiser/external-VCXO choice, are passed through to registered outputs.

Top module: `lock_search_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `std_sel` is 0 (0 = 6.552 MHz standard A, 1 = 5.85 MHz standard B) and `locked` is 0; the block comes out of reset in automatic mode.
- R2: In automatic mode with `lock_in` low, `std_sel` inverts on the clock edge that samples the `dwell_ticks`-th `tick` pulse of the current window. A new window starts at that edge. A `dwell_ticks` value of 0 behaves as 1.
- R3: `locked` equals the value of `lock_in` one clock earlier. When `lock_in` and `tick` are high on the same cycle, lock wins and `std_sel` is not changed.
- R4: While lock is held and `force_en` is low, `std_sel` does not change.
- R5: After lock is lost, `std_sel` is held while `holdoff_ticks` ticks are counted. The count starts from zero when lock drops. If lock returns first, the controller goes back to the locked state. When the holdoff expires, the search resumes on the same standard with a fresh dwell window. A holdoff of 0 behaves as 1.
- R6: While `force_en` is high, `std_sel` takes the value of `force_std` one cycle later and ticks have no effect. When `force_en` is released, automatic operation continues from the forced standard with a fresh window.
- R7: `xtal_sel` is `xtal_sel_reg` delayed by one cycle (0 = crystal 1, 1 = crystal 2). `ext_vcxo` is `synth_mode_reg` delayed by one cycle (0 = internal synthesised reference, 1 = external dual-VCXO crystal). Both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick, one cycle per tick |
| lock_in | input | 1 | Carrier loop lock flag |
| force_en | input | 1 | Register override enable |
| force_std | input | 1 | Standard to use while overridden |
| xtal_sel_reg | input | 1 | Crystal choice register bit |
| synth_mode_reg | input | 1 | Synthesiser / external VCXO register bit |
| dwell_ticks | input | CNT_W | Ticks per lock attempt |
| holdoff_ticks | input | CNT_W | Ticks of lost lock before the search restarts |
| std_sel | output | 1 | Selected standard |
| xtal_sel | output | 1 | Registered crystal select |
| ext_vcxo | output | 1 | Registered reference mode |
| locked | output | 1 | Lock status |

## Verification
The bench checks that the window boundary falls exactly on the Nth tick. A design off by one there would switch a tick early or late. It also checks that lock takes priority over a tick on the same cycle; a design that got this wrong would switch away just as the loop locked. The holdoff path is tested for a fresh count after each relock and for resuming the search without changing the standard. A design that reused a stale count would resume too early, and one that toggled the standard on resume would skip a lock attempt. Further cases cover a dwell of zero, release from the override, and the one-cycle latency of the pass-through bits.

// File: rtl/lss_pkg.sv
package lss_pkg;
    typedef enum logic {
        STD_A = 1'b0,
        STD_B = 1'b1
    } std_e;

    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_HOLDOFF = 2'd2
    } lss_state_e;

    function automatic std_e other_std(input std_e s);
        return (s == STD_A) ? STD_B : STD_A;
    endfunction
endpackage

// File: rtl/lss_timer.sv
module lss_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] count;
    logic [EXT_W-1:0] next_ext;

    assign next_ext = {1'b0, count} + EXT_W'(1);
    assign expire   = inc && (next_ext >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clr || expire) begin
            count <= '0;
        end else if (inc) begin
            count <= next_ext[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/lss_fsm.sv
module lss_fsm
    import lss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       lock_in,
    input  logic       force_en,
    input  std_e       force_std,
    input  logic       dwell_exp,
    input  logic       hold_exp,
    output logic       dwell_clr,
    output logic       hold_clr,
    output logic       tick_q,
    output std_e       std_q,
    output lss_state_e state_q
);
    lss_state_e state_d;
    std_e       std_d;

    assign tick_q    = tick && !force_en;
    assign dwell_clr = force_en || lock_in || (state_q != ST_SEARCH);
    assign hold_clr  = force_en || lock_in || (state_q != ST_HOLDOFF);

    always_comb begin
        state_d = state_q;
        std_d   = std_q;
        if (force_en) begin
            std_d   = force_std;
            state_d = lock_in ? ST_LOCKED : ST_SEARCH;
        end else begin
            unique case (state_q)
                ST_SEARCH: begin
                    if (lock_in) begin
                        state_d = ST_LOCKED;
                    end else if (dwell_exp) begin
                        std_d = other_std(std_q);
                    end
                end
                ST_LOCKED: begin
                    if (!lock_in) state_d = ST_HOLDOFF;
                end
                ST_HOLDOFF: begin
                    if (lock_in) begin
                        state_d = ST_LOCKED;
                    end else if (hold_exp) begin
                        state_d = ST_SEARCH;
                    end
                end
                default: state_d = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SEARCH;
            std_q   <= STD_A;
        end else begin
            state_q <= state_d;
            std_q   <= std_d;
        end
    end
endmodule

// File: rtl/lock_search_ctrl.sv
module lock_search_ctrl
    import lss_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             lock_in,
    input  logic             force_en,
    input  logic             force_std,
    input  logic             xtal_sel_reg,
    input  logic             synth_mode_reg,
    input  logic [CNT_W-1:0] dwell_ticks,
    input  logic [CNT_W-1:0] holdoff_ticks,
    output logic             std_sel,
    output logic             xtal_sel,
    output logic             ext_vcxo,
    output logic             locked
);
    logic       dwell_exp, hold_exp, dwell_clr, hold_clr, tick_q;
    std_e       std_q;
    lss_state_e state_q;

    lss_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .lock_in   (lock_in),
        .force_en  (force_en),
        .force_std (std_e'(force_std)),
        .dwell_exp (dwell_exp),
        .hold_exp  (hold_exp),
        .dwell_clr (dwell_clr),
        .hold_clr  (hold_clr),
        .tick_q    (tick_q),
        .std_q     (std_q),
        .state_q   (state_q)
    );

    lss_timer #(.CNT_W(CNT_W)) u_dwell (
        .clk    (clk),
        .rst    (rst),
        .clr    (dwell_clr),
        .inc    (tick_q && !dwell_clr),
        .limit  (dwell_ticks),
        .expire (dwell_exp)
    );

    lss_timer #(.CNT_W(CNT_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .clr    (hold_clr),
        .inc    (tick_q && !hold_clr),
        .limit  (holdoff_ticks),
        .expire (hold_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xtal_sel <= 1'b0;
            ext_vcxo <= 1'b0;
        end else begin
            xtal_sel <= xtal_sel_reg;
            ext_vcxo <= synth_mode_reg;
        end
    end

    assign std_sel = std_q;
    assign locked  = (state_q == ST_LOCKED);
endmodule

// File: rtl/lock_search_ctrl_chk.sv
module lock_search_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic lock_in,
    input logic force_en,
    input logic force_std,
    input logic xtal_sel_reg,
    input logic synth_mode_reg,
    input logic std_sel,
    input logic xtal_sel,
    input logic ext_vcxo,
    input logic locked
);
    // R1: the first cycle after reset starts on standard A, not locked
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!std_sel && !locked));

    // R2 and R3: in automatic mode, the standard changes only on a tick taken without lock
    a_r2_switch_on_tick: assert property (@(posedge clk) disable iff (rst)
        (!force_en && (!tick || lock_in)) |=> $stable(std_sel));

    // R3: the lock status follows the lock flag one cycle later
    a_r3_lock_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (locked == $past(lock_in)));

    // R4: the standard is held while locked
    a_r4_hold_locked: assert property (@(posedge clk) disable iff (rst)
        (locked && !force_en) |=> $stable(std_sel));

    // R6: the override sets the standard
    a_r6_force: assert property (@(posedge clk) disable iff (rst)
        force_en |=> (std_sel == $past(force_std)));

    // R7: the pass-through bits are delayed by one cycle
    a_r7_xtal: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (xtal_sel == $past(xtal_sel_reg)));
    a_r7_vcxo: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ext_vcxo == $past(synth_mode_reg)));
endmodule

bind lock_search_ctrl lock_search_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .tick           (tick),
    .lock_in        (lock_in),
    .force_en       (force_en),
    .force_std      (force_std),
    .xtal_sel_reg   (xtal_sel_reg),
    .synth_mode_reg (synth_mode_reg),
    .std_sel        (std_sel),
    .xtal_sel       (xtal_sel),
    .ext_vcxo       (ext_vcxo),
    .locked         (locked)
);

// File: tb/sim_lock_search_ctrl.sv
`timescale 1ns/1ps
module sim_lock_search_ctrl;
    localparam int CNT_W = 8;
    localparam int NV    = 21;
    // fields: tick, lock_in, force_en, force_std, expected std_sel, expected locked
    localparam logic [5:0] VEC [NV] = '{
        6'b1000_00, 6'b1000_10, 6'b0000_10, 6'b1000_10, 6'b1000_00, // R2 windows
        6'b1100_01, 6'b1100_01,                                     // R3 lock beats tick
        6'b1000_00, 6'b1000_00, 6'b0100_01,                         // R5 relock in holdoff
        6'b0000_00, 6'b1000_00, 6'b1000_00,                         // R5 holdoff expiry, same std
        6'b1000_00, 6'b1000_10,                                     // R5 fresh window
        6'b1010_00, 6'b1011_10, 6'b1011_10, 6'b0111_11,             // R6 override
        6'b1100_11, 6'b0000_10                                      // R6 release
    };

    logic clk = 1'b0, rst = 1'b1;
    logic tick = 0, lock_in = 0, force_en = 0, force_std = 0;
    logic xtal_sel_reg = 0, synth_mode_reg = 0;
    logic [CNT_W-1:0] dwell_ticks = 8'd2, holdoff_ticks = 8'd2;
    logic std_sel, xtal_sel, ext_vcxo, locked;
    int   n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    lock_search_ctrl #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .lock_in(lock_in),
        .force_en(force_en), .force_std(force_std),
        .xtal_sel_reg(xtal_sel_reg), .synth_mode_reg(synth_mode_reg),
        .dwell_ticks(dwell_ticks), .holdoff_ticks(holdoff_ticks),
        .std_sel(std_sel), .xtal_sel(xtal_sel), .ext_vcxo(ext_vcxo),
        .locked(locked)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic t, input logic l);
        tick = t; lock_in = l;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; tick = 0; lock_in = 0; force_en = 0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 std", std_sel, 1'b0);
        check("R1 locked", locked, 1'b0);
        check("R7 xtal reset", xtal_sel, 1'b0);
        check("R7 vcxo reset", ext_vcxo, 1'b0);

        for (int i = 0; i < NV; i++) begin
            tick = VEC[i][5]; lock_in = VEC[i][4];
            force_en = VEC[i][3]; force_std = VEC[i][2];
            @(negedge clk);
            check($sformatf("R2-R6 vec%0d std", i), std_sel, VEC[i][1]);
            check($sformatf("R3 vec%0d locked", i), locked, VEC[i][0]);
        end
        force_en = 0;

        // R2: a dwell of zero switches on every tick
        do_reset();
        dwell_ticks = 8'd0;
        cyc(1, 0); check("R2 dwell0 a", std_sel, 1'b1);
        cyc(1, 0); check("R2 dwell0 b", std_sel, 1'b0);
        cyc(0, 0); check("R2 dwell0 idle", std_sel, 1'b0);
        cyc(1, 0); check("R2 dwell0 c", std_sel, 1'b1);

        // R2: a long window switches exactly on the 20th tick
        do_reset();
        dwell_ticks = 8'd20;
        for (int k = 0; k < 19; k++) begin
            cyc(1, 0);
            cyc(0, 0);
        end
        check("R2 long before", std_sel, 1'b0);
        cyc(1, 0); check("R2 long at", std_sel, 1'b1);

        // R5: holdoff of zero resumes after one tick, on the same standard
        do_reset();
        dwell_ticks = 8'd5; holdoff_ticks = 8'd0;
        cyc(0, 1); check("R3 lock", locked, 1'b1);
        cyc(0, 0); check("R5 drop", locked, 1'b0);
        cyc(1, 0); check("R5 hold0 std", std_sel, 1'b0);
        for (int k = 0; k < 4; k++) cyc(1, 0);
        check("R5 fresh window before", std_sel, 1'b0);
        cyc(1, 0); check("R5 fresh window at", std_sel, 1'b1);

        // R7: pass-through latency
        xtal_sel_reg = 1; synth_mode_reg = 0;
        @(negedge clk);
        check("R7 xtal", xtal_sel, 1'b1);
        check("R7 vcxo", ext_vcxo, 1'b0);
        xtal_sel_reg = 0; synth_mode_reg = 1;
        @(negedge clk);
        check("R7 xtal b", xtal_sel, 1'b0);
        check("R7 vcxo b", ext_vcxo, 1'b1);

        // R1: reset in the middle of operation
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid std", std_sel, 1'b0);
        check("R1 mid xtal", ext_vcxo, 1'b0);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule